// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Controller

This block is the digital sequencer of an integrating (dual-slope) analog-to-digital converter. A single cycle counter times a fixed-length conversion made of three phases: auto-zero, input integrate and deintegrate. The external analog front end is controlled through four switch-select outputs, exactly one of which is active at any time. At the end of input integrate the block samples the comparator to decide the input sign. That sign chooses which reference switch pair drives the deintegrate ramp. The block then counts deintegrate clocks until the comparator flips.

When the comparator flips, the count is captured and the front end goes back to auto-zero for the rest of the deintegrate window, so every conversion lasts the same number of clocks. The count, the sign and an overrange flag are moved to the output register together at the end of the deintegrate window, with a one-clock valid strobe. A run/hold input selects between back-to-back conversions and single conversions on request. A busy output marks the active part of each conversion, so external logic such as a multiplexer can synchronise to it.

The sequencer has five states, held in `dsc_state_e`:

- `ST_HOLD`: idle in auto-zero.
- `ST_AZ`: timed auto-zero.
- `ST_INT`: input integrate.
- `ST_DEINT`: reference deintegrate.
- `ST_FILL`: auto-zero for the deintegrate time left after a crossing.

Its transitions are:

- HOLD→AZ when run/hold is high.
- AZ→INT on the last auto-zero clock.
- INT→DEINT on the last integrate clock.
- DEINT→FILL on a zero crossing.
- DEINT or FILL → AZ at the end of the cycle if run/hold is high, otherwise → HOLD.

Top module: `dsc_ctrl`

## Requirements
- R1: With N = 2^INT_BITS, a conversion is N clocks of auto-zero, then N clocks of integrate, then a deintegrate window of 2N clocks. In free run, successive result strobes are exactly 4N clocks apart.
- R2: The polarity is the value of `comp_in` at the clock edge that ends the last integrate clock (1 = positive input). Comparator values earlier in integrate have no effect on it.
- R3: Exactly one select is high at every cycle:
  - `sel_int` during integrate.
  - `sel_ref_neg` during deintegrate with positive polarity.
  - `sel_ref_pos` during deintegrate with negative polarity.
  - `sel_az` in every other state.
- R4: A zero crossing is a deintegrate clock on which `comp_in` differs from the latched polarity. The captured count is the number of deintegrate clocks before that one (0 to 2N-1). From the next cycle on, `sel_az` is high until the window ends, and the window length does not change.
- R5: If no crossing occurs in the whole deintegrate window, `overrange` is 1 and `result` saturates at 2N-1 (all ones).
- R6: `result`, `polarity` and `overrange` change only in the cycle after the deintegrate window ends. In that same cycle `result_valid` is high for exactly one clock.
- R7: A crossing on the first deintegrate clock gives `result` 0 together with the true latched polarity.
- R8: If `run_hold` is low at the end of a window, the block idles with `sel_az` high, `busy` low and no strobes. A single clock of `run_hold` high then starts exactly one conversion, beginning with a full auto-zero.
- R9: `busy` is high during integrate and during the whole deintegrate window, including the auto-zero fill. It is low during the timed auto-zero and while idle.
- R10: While reset is asserted, the block idles with `sel_az` high, `busy` low, `result_valid` low and `result`, `polarity` and `overrange` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Comparator output, 1 = integrator above its zero point |
| run_hold | input | 1 | 1 = convert continuously, 0 = stop after the current conversion |
| sel_az | output | 1 | Auto-zero switch select |
| sel_int | output | 1 | Input integrate switch select |
| sel_ref_neg | output | 1 | Deintegrate with the negative reference |
| sel_ref_pos | output | 1 | Deintegrate with the positive reference |
| busy | output | 1 | Conversion activity status |
| result | output | INT_BITS+1 | Latched deintegrate count |
| polarity | output | 1 | Latched sign, 1 = positive |
| overrange | output | 1 | Latched overrange flag |
| result_valid | output | 1 | One-clock strobe marking new result |

## Verification
A corrupted cycle counter or state register would show up at the ports within one conversion, as a misplaced select edge. It would also change the spacing between result strobes, which the bench measures against 4N. A polarity latch taken on the wrong clock would pick the wrong reference select on the very first deintegrate cycle. A capture register that misses the crossing shows as a wrong count or a spurious overrange at the next strobe, and a result register that updates early shows a changed `result` during the fill interval, before the strobe.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_AZ    = 3'd1,
        ST_INT   = 3'd2,
        ST_DEINT = 3'd3,
        ST_FILL  = 3'd4
    } dsc_state_e;

    // index of each switch select inside the select vector
    localparam int SEL_AZ  = 0;
    localparam int SEL_INT = 1;
    localparam int SEL_NEG = 2;
    localparam int SEL_POS = 3;
    localparam int SEL_W   = 4;

endpackage

// File: rtl/dsc_cycle_timer.sv
module dsc_cycle_timer #(
    parameter int INT_BITS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    output logic [INT_BITS+1:0]   cyc,
    output logic                  az_last,
    output logic                  int_last,
    output logic                  cyc_last
);
    localparam int CYC_W = INT_BITS + 2;
    localparam logic [CYC_W-1:0] AZ_END  = CYC_W'((1 << INT_BITS) - 1);
    localparam logic [CYC_W-1:0] INT_END = CYC_W'((2 << INT_BITS) - 1);
    localparam logic [CYC_W-1:0] CYC_END = {CYC_W{1'b1}};

    // free counter across the whole conversion; wraps to zero at cycle end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (run_en) begin
            cyc <= cyc + 1'b1;
        end
    end

    always_comb begin
        az_last  = (cyc == AZ_END);
        int_last = (cyc == INT_END);
        cyc_last = (cyc == CYC_END);
    end

    // R1: the counter only ever leaves zero while running
    p_idle_no_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && $past(!run_en) && $past(rst_n)) |-> $stable(cyc));

endmodule

// File: rtl/dsc_seq_fsm.sv
module dsc_seq_fsm
    import dsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               comp_in,
    input  logic               run_hold,
    input  logic               az_last,
    input  logic               int_last,
    input  logic               cyc_last,
    output dsc_state_e         st,
    output logic               pol_q,
    output logic               crossing,
    output logic [SEL_W-1:0]   sel,
    output logic               busy
);
    dsc_state_e st_nx;

    // a crossing is the comparator disagreeing with the sign latched at integrate end
    assign crossing = (st == ST_DEINT) && (comp_in != pol_q);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HOLD:  st_nx = run_hold ? ST_AZ : ST_HOLD;
            ST_AZ:    st_nx = az_last ? ST_INT : ST_AZ;
            ST_INT:   st_nx = int_last ? ST_DEINT : ST_INT;
            ST_DEINT: begin
                if (cyc_last)      st_nx = run_hold ? ST_AZ : ST_HOLD;
                else if (crossing) st_nx = ST_FILL;
                else               st_nx = ST_DEINT;
            end
            ST_FILL:  st_nx = cyc_last ? (run_hold ? ST_AZ : ST_HOLD) : ST_FILL;
            default:  st_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HOLD;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (st == ST_INT && int_last) begin
            pol_q <= comp_in;
        end
    end

    always_comb begin
        sel  = '0;
        busy = 1'b0;
        unique case (st)
            ST_HOLD, ST_AZ: sel[SEL_AZ] = 1'b1;
            ST_INT: begin
                sel[SEL_INT] = 1'b1;
                busy         = 1'b1;
            end
            ST_DEINT: begin
                if (pol_q) sel[SEL_NEG] = 1'b1;
                else       sel[SEL_POS] = 1'b1;
                busy = 1'b1;
            end
            ST_FILL: begin
                sel[SEL_AZ] = 1'b1;
                busy        = 1'b1;
            end
            default: sel[SEL_AZ] = 1'b1;
        endcase
    end

    // R2: the sign cannot move while deintegrate is running
    p_pol_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEINT && $past(st) == ST_DEINT && $past(rst_n)) |-> $stable(pol_q));

    // R1: integrate is always entered from timed auto-zero
    p_int_after_az_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INT && $past(st) != ST_INT && $past(rst_n)) |-> $past(st) == ST_AZ);

endmodule

// File: rtl/dsc_result_latch.sv
module dsc_result_latch #(
    parameter int INT_BITS = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_start,
    input  logic                 crossing,
    input  logic [INT_BITS:0]    deint_cnt,
    input  logic                 win_end,
    input  logic                 pol_q,
    output logic [INT_BITS:0]    result,
    output logic                 polarity,
    output logic                 overrange,
    output logic                 result_valid
);
    localparam int CNT_W = INT_BITS + 1;
    localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

    logic             hit_q;
    logic [CNT_W-1:0] cap_q;
    logic             fin_hit;
    logic [CNT_W-1:0] fin_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            cap_q <= '0;
        end else if (cyc_start) begin
            hit_q <= 1'b0;
        end else if (crossing && !hit_q) begin
            hit_q <= 1'b1;
            cap_q <= deint_cnt;
        end
    end

    // a crossing on the final window clock is still a valid reading
    always_comb begin
        fin_hit = hit_q | crossing;
        if (hit_q)         fin_cnt = cap_q;
        else if (crossing) fin_cnt = deint_cnt;
        else               fin_cnt = FULL_SCALE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            polarity     <= 1'b0;
            overrange    <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= win_end;
            if (win_end) begin
                result    <= fin_cnt;
                polarity  <= pol_q;
                overrange <= !fin_hit;
            end
        end
    end

    // R6: output register moves only together with the strobe
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result) && $stable(overrange) && $stable(polarity)));

    // R6: strobe lasts one clock
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R5: overrange reading always saturates
    p_ovr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == FULL_SCALE));

endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
    import dsc_pkg::*;
#(
    parameter int INT_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                comp_in,
    input  logic                run_hold,
    output logic                sel_az,
    output logic                sel_int,
    output logic                sel_ref_neg,
    output logic                sel_ref_pos,
    output logic                busy,
    output logic [INT_BITS:0]   result,
    output logic                polarity,
    output logic                overrange,
    output logic                result_valid
);
    logic [INT_BITS+1:0] cyc;
    logic                az_last;
    logic                int_last;
    logic                cyc_last;
    dsc_state_e          st;
    logic                pol_q;
    logic                crossing;
    logic [SEL_W-1:0]    sel;
    logic                run_en;
    logic                win_end;
    logic                cyc_start;

    assign run_en    = (st != ST_HOLD);
    assign win_end   = cyc_last && (st == ST_DEINT || st == ST_FILL);
    assign cyc_start = (st == ST_AZ) && az_last;

    dsc_cycle_timer #(.INT_BITS(INT_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .cyc      (cyc),
        .az_last  (az_last),
        .int_last (int_last),
        .cyc_last (cyc_last)
    );

    dsc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .comp_in  (comp_in),
        .run_hold (run_hold),
        .az_last  (az_last),
        .int_last (int_last),
        .cyc_last (cyc_last),
        .st       (st),
        .pol_q    (pol_q),
        .crossing (crossing),
        .sel      (sel),
        .busy     (busy)
    );

    // within deintegrate the low bits of the cycle count are the elapsed clocks
    dsc_result_latch #(.INT_BITS(INT_BITS)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_start    (cyc_start),
        .crossing     (crossing),
        .deint_cnt    (cyc[INT_BITS:0]),
        .win_end      (win_end),
        .pol_q        (pol_q),
        .result       (result),
        .polarity     (polarity),
        .overrange    (overrange),
        .result_valid (result_valid)
    );

    assign sel_az      = sel[SEL_AZ];
    assign sel_int     = sel[SEL_INT];
    assign sel_ref_neg = sel[SEL_NEG];
    assign sel_ref_pos = sel[SEL_POS];

    // R3: one switch select at a time
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_az, sel_int, sel_ref_neg, sel_ref_pos}) == 1);

    // R8: idle keeps the cycle timer parked at zero
    p_idle_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (cyc == '0));

    // R4: fill only follows a deintegrate clock
    p_fill_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && $past(st) != ST_FILL && $past(rst_n)) |-> $past(st) == ST_DEINT);

endmodule

// File: tb/dsc_ctrl_tb_top.sv
module dsc_ctrl_tb_top;
    localparam int IB = 4;
    localparam int N  = 1 << IB;
    localparam int CW = IB + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          comp_in = 1'b0;
    logic          run_hold = 1'b1;
    logic          sel_az, sel_int, sel_ref_neg, sel_ref_pos, busy;
    logic [CW-1:0] result;
    logic          polarity, overrange, result_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_n = 0;
    int last_valid_t = -1;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (cyc_n > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc_n);
            $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
            $finish;
        end
    end

    dsc_ctrl #(.INT_BITS(IB)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .comp_in      (comp_in),
        .run_hold     (run_hold),
        .sel_az       (sel_az),
        .sel_int      (sel_int),
        .sel_ref_neg  (sel_ref_neg),
        .sel_ref_pos  (sel_ref_pos),
        .busy         (busy),
        .result       (result),
        .polarity     (polarity),
        .overrange    (overrange),
        .result_valid (result_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(sel_az && !sel_int && !sel_ref_neg && !sel_ref_pos, "R10 select", {sel_az, sel_int, sel_ref_neg, sel_ref_pos}, 8);
        chk(!busy && !result_valid, "R10 busy/valid", {busy, result_valid}, 0);
        chk(result == 0 && !polarity && !overrange, "R10 result", int'(result), 0);
    endtask

    // one conversion: sign pos, crossing after k deintegrate clocks (k < 0: none)
    task automatic t_conv(input bit pos, input int k, input bit free_run);
        int n;
        int t0;
        logic [CW-1:0] old_res;
        int exp_res;
        while (!sel_int) begin
            chk(!busy, "R9 busy low in auto-zero", busy, 0);
            @(negedge clk);
        end
        n = 0;
        while (sel_int) begin
            if (n == 0) comp_in = !pos;
            if (n == N - 2) comp_in = pos;
            if (n == 0) chk(busy, "R9 busy in integrate", busy, 1);
            n++;
            @(negedge clk);
        end
        t0 = cyc_n;
        chk(n == N, "R1 integrate length", n, N);
        if (pos) chk(sel_ref_neg && !sel_ref_pos, "R2 R3 positive picks negative ref", {sel_ref_neg, sel_ref_pos}, 2);
        else     chk(sel_ref_pos && !sel_ref_neg, "R2 R3 negative picks positive ref", {sel_ref_neg, sel_ref_pos}, 1);
        old_res = result;
        if (k >= 0) begin
            repeat (k) @(negedge clk);
            comp_in = !pos;
            @(negedge clk);
            chk(sel_az && busy, "R4 R9 fill in auto-zero while busy", {sel_az, busy}, 3);
            chk(result == old_res && !result_valid, "R6 no early update", int'(result), int'(old_res));
            exp_res = k;
        end else begin
            exp_res = (1 << CW) - 1;
        end
        while (!result_valid) @(negedge clk);
        chk(cyc_n - t0 == 2 * N, "R1 R4 window length fixed", cyc_n - t0, 2 * N);
        chk(int'(result) == exp_res, (k == 0) ? "R7 zero reading" : ((k < 0) ? "R5 saturated count" : "R4 count"), int'(result), exp_res);
        chk(polarity == pos, (k == 0) ? "R7 true sign at zero" : "R2 polarity", polarity, pos);
        chk(overrange == (k < 0), "R5 overrange flag", overrange, (k < 0));
        if (free_run && last_valid_t >= 0)
            chk(cyc_n - last_valid_t == 4 * N, "R1 strobe period", cyc_n - last_valid_t, 4 * N);
        last_valid_t = cyc_n;
        @(negedge clk);
        chk(!result_valid, "R6 strobe one clock", result_valid, 0);
    endtask

    task automatic t_hold();
        int starts;
        bit prev_int;
        run_hold = 1'b0;
        t_conv(1'b1, 9, 1'b1);
        repeat (3 * N) begin
            chk(sel_az && !busy && !result_valid, "R8 idle", {sel_az, busy, result_valid}, 4);
            @(negedge clk);
        end
        run_hold = 1'b1;
        @(negedge clk);
        run_hold = 1'b0;
        t_conv(1'b0, 2 * N - 3, 1'b0);
        starts = 0;
        prev_int = 1'b0;
        repeat (5 * N) begin
            if (sel_int && !prev_int) starts++;
            prev_int = sel_int;
            @(negedge clk);
        end
        chk(starts == 0, "R8 single conversion per request", starts, 0);
        run_hold = 1'b1;
    endtask

    initial begin
        t_reset_state();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_conv(1'b1, 5, 1'b1);
        t_conv(1'b0, 17, 1'b1);
        t_conv(1'b0, 0, 1'b1);
        t_conv(1'b1, -1, 1'b1);
        t_conv(1'b1, 2 * N - 2, 1'b1);
        t_conv(1'b0, -1, 1'b1);
        t_hold();
        t_conv(1'b1, 3, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule